// File: doc/BRIEF.md
# Audio Codec Power-Up Sequencer

After a system reset, this block brings a serially programmed audio codec out of reset and loads its start-up configuration. It first moves the codec's reset and chip-select pins through a fixed three-step pattern, holding each step for a set number of clock cycles. It then reads a constant on-chip table of register address and value pairs and passes each pair to a separate serial writer, one pair at a time. After each pair it waits until the writer has finished.

The table ends with an all-ones entry. When the sequencer reaches that entry it raises a completion flag, and the flag stays high until the next reset. The multiplexer entries and the power-up entry come first in the table, so the output paths are settled before the analog stages turn on. This keeps pops at power-up low.

Top module: `codec_init_seq`

## Requirements
- R1: While `rstN` is low: `codecResetN`=1, `codecCsN`=0, `wrStart`=0, `initDone`=0.
- R2: After reset is released, `codecResetN` falls. `STEP_CYCLES` cycles later `codecCsN` rises. `STEP_CYCLES` cycles after that `codecResetN` rises. No write starts until at least `STEP_CYCLES` further cycles have passed. Once `codecResetN` rises, both pins stay high.
- R3: The first four writes, as {`wrAddr`, `wrData`}, are 0x1B=0x044, 0x1C=0x00B, 0x1D=0x009 and 0x18=0x000.
- R4: The fifth write is 0x16=0x122. The sixth write is 0x17=0x022.
- R5: Writes seven to fourteen set addresses 0x00 to 0x07, in ascending order, to 0. The fifteenth write sets 0x08 to 0x100.
- R6: Writes sixteen to twenty-three set addresses 0x09 to 0x10, in ascending order, to 0x0FF. The twenty-fourth write sets 0x11 to 0x1FF.
- R7: The last six writes are 0x12=0, 0x13=0x090, 0x14=0, 0x15=0, 0x19=0 and 0x1A=0, in that order. After them the sequencer reaches the all-ones end entry, raises `initDone` and makes no further writes. A complete sequence therefore has exactly 30 writes.
- R8: `wrStart` is a pulse one cycle long. It is raised only when `wrBusy` was low at the clock edge that raised it. The writer must raise `wrBusy` within the cycle in which `wrStart` is high. The next pulse comes only after `wrBusy` has returned low.
- R9: `initDone` stays high until reset. A reset in the middle of the sequence restarts it from the pin pattern and the first table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrBusy | input | 1 | Serial writer is shifting a word |
| codecResetN | output | 1 | Codec reset pin, active low |
| codecCsN | output | 1 | Codec chip-select pin, active low |
| wrStart | output | 1 | One-cycle request to the writer |
| wrAddr | output | 7 | Codec register address for the request |
| wrData | output | 9 | Codec register value for the request |
| initDone | output | 1 | Configuration finished |

## Verification
The bench builds the block with `STEP_CYCLES` = 3, so the length of each pin phase can be counted exactly, cycle by cycle. A writer model in the bench holds `wrBusy` for a random time after each request. This tests the wait between writes with both quick and slow writers. One run is stopped by a reset partway through the table, which shows that the sequence starts again from the pin pattern.

// File: rtl/codec_init_pkg.sv
package codec_init_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 9;
  localparam int ENTRY_W = ADDR_W + DATA_W;
  localparam int IDX_W   = 5;

  typedef enum logic [2:0] {
    S_BOOT, S_RLO, S_CHI, S_RHI, S_ISSUE, S_SETTLE, S_WAIT, S_DONE
  } seqState_t;

  typedef struct packed {
    logic loadStep;
    logic pinRstLow;
    logic pinCsHigh;
    logic pinRstHigh;
    logic issue;
    logic advIdx;
    logic setDone;
  } ctrlStrobes_t;

  // Start-up table; the order is part of the behaviour (pop suppression).
  function automatic logic [ENTRY_W-1:0] romEntry(input logic [IDX_W-1:0] idx);
    logic [ENTRY_W-1:0] e;
    e = '1;
    if (idx >= 5'd6 && idx <= 5'd13)
      e = {ADDR_W'(idx - 5'd6), 9'h000};
    else if (idx >= 5'd15 && idx <= 5'd22)
      e = {ADDR_W'(idx - 5'd6), 9'h0FF};
    else begin
      case (idx)
        5'd0:  e = {7'h1B, 9'h044};
        5'd1:  e = {7'h1C, 9'h00B};
        5'd2:  e = {7'h1D, 9'h009};
        5'd3:  e = {7'h18, 9'h000};
        5'd4:  e = {7'h16, 9'h122};
        5'd5:  e = {7'h17, 9'h022};
        5'd14: e = {7'h08, 9'h100};
        5'd23: e = {7'h11, 9'h1FF};
        5'd24: e = {7'h12, 9'h000};
        5'd25: e = {7'h13, 9'h090};
        5'd26: e = {7'h14, 9'h000};
        5'd27: e = {7'h15, 9'h000};
        5'd28: e = {7'h19, 9'h000};
        5'd29: e = {7'h1A, 9'h000};
        default: e = '1;
      endcase
    end
    return e;
  endfunction
endpackage

// File: rtl/codec_init_ctrl.sv
module codec_init_ctrl
  import codec_init_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         stepDone,
  input  logic         entryEnd,
  input  logic         wrBusy,
  output ctrlStrobes_t strb
);
  seqState_t curState, nxtState;

  always_ff @(posedge clk) begin
    if (!rstN) curState <= S_BOOT;
    else       curState <= nxtState;
  end

  always_comb begin
    strb     = '0;
    nxtState = curState;
    case (curState)
      S_BOOT: begin
        strb.pinRstLow = 1'b1;
        strb.loadStep  = 1'b1;
        nxtState       = S_RLO;
      end
      S_RLO: if (stepDone) begin
        strb.pinCsHigh = 1'b1;
        strb.loadStep  = 1'b1;
        nxtState       = S_CHI;
      end
      S_CHI: if (stepDone) begin
        strb.pinRstHigh = 1'b1;
        strb.loadStep   = 1'b1;
        nxtState        = S_RHI;
      end
      S_RHI: if (stepDone) nxtState = S_ISSUE;
      S_ISSUE: begin
        if (entryEnd) begin
          strb.setDone = 1'b1;
          nxtState     = S_DONE;
        end else if (!wrBusy) begin
          strb.issue = 1'b1;
          nxtState   = S_SETTLE;
        end
      end
      S_SETTLE: nxtState = S_WAIT;
      S_WAIT: if (!wrBusy) begin
        strb.advIdx = 1'b1;
        nxtState    = S_ISSUE;
      end
      S_DONE: nxtState = S_DONE;
      default: nxtState = S_BOOT;
    endcase
  end
endmodule

// File: rtl/codec_init_dpath.sv
module codec_init_dpath
  import codec_init_pkg::*;
#(
  parameter int STEP_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  output logic              stepDone,
  output logic              entryEnd,
  output logic              codecResetN,
  output logic              codecCsN,
  output logic              wrStart,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              initDone
);
  localparam int STEP_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES + 1) : 1;
  localparam logic [STEP_W-1:0] STEP_LOAD = STEP_W'(STEP_CYCLES - 1);

  logic [STEP_W-1:0]  stepCnt;
  logic [IDX_W-1:0]   entryIdx;
  logic [ENTRY_W-1:0] curEntry;

  assign curEntry = romEntry(entryIdx);
  assign entryEnd = (curEntry == '1);
  assign stepDone = (stepCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt     <= '0;
      entryIdx    <= '0;
      codecResetN <= 1'b1;
      codecCsN    <= 1'b0;
      wrStart     <= 1'b0;
      wrAddr      <= '0;
      wrData      <= '0;
      initDone    <= 1'b0;
    end else begin
      if (strb.loadStep)      stepCnt <= STEP_LOAD;
      else if (!stepDone)     stepCnt <= stepCnt - 1'b1;
      if (strb.pinRstLow)     codecResetN <= 1'b0;
      if (strb.pinRstHigh)    codecResetN <= 1'b1;
      if (strb.pinCsHigh)     codecCsN    <= 1'b1;
      wrStart <= strb.issue;
      if (strb.issue) begin
        wrAddr <= curEntry[ENTRY_W-1:DATA_W];
        wrData <= curEntry[DATA_W-1:0];
      end
      if (strb.advIdx)        entryIdx <= entryIdx + 1'b1;
      if (strb.setDone)       initDone <= 1'b1;
    end
  end
endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq #(
  parameter int STEP_CYCLES = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrBusy,
  output logic       codecResetN,
  output logic       codecCsN,
  output logic       wrStart,
  output logic [6:0] wrAddr,
  output logic [8:0] wrData,
  output logic       initDone
);
  import codec_init_pkg::*;

  ctrlStrobes_t strb;
  logic stepDone, entryEnd;

  codec_init_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stepDone(stepDone), .entryEnd(entryEnd),
    .wrBusy(wrBusy), .strb(strb)
  );

  codec_init_dpath #(.STEP_CYCLES(STEP_CYCLES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .stepDone(stepDone),
    .entryEnd(entryEnd), .codecResetN(codecResetN), .codecCsN(codecCsN),
    .wrStart(wrStart), .wrAddr(wrAddr), .wrData(wrData), .initDone(initDone)
  );
endmodule

// File: rtl/codec_init_checker.sv
module codec_init_checker (
  input logic clk,
  input logic rstN,
  input logic wrBusy,
  input logic codecResetN,
  input logic codecCsN,
  input logic wrStart,
  input logic initDone
);
  AST_CS_AFTER_RESET_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(codecCsN) |-> !codecResetN); // R2
  AST_RELEASE_AFTER_CS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(codecResetN) |-> codecCsN); // R2
  AST_DONE_PINS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (codecResetN && codecCsN)); // R2
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |-> !$past(wrBusy)); // R8
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |=> !wrStart); // R8
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> !wrStart); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone); // R9
endmodule

bind codec_init_seq codec_init_checker u_chk (
  .clk(clk), .rstN(rstN), .wrBusy(wrBusy), .codecResetN(codecResetN),
  .codecCsN(codecCsN), .wrStart(wrStart), .initDone(initDone)
);

// File: tb/sim_codec_init_seq.sv
`timescale 1ns/1ps
module sim_codec_init_seq;
  localparam int STEP = 3;
  localparam int NWR  = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrBusy = 1'b0;
  logic codecResetN, codecCsN, wrStart, initDone;
  logic [6:0] wrAddr;
  logic [8:0] wrData;

  int checks = 0;
  int failures = 0;
  int writeCnt = 0;
  int latMax = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  codec_init_seq #(.STEP_CYCLES(STEP)) u0 (
    .clk(clk), .rstN(rstN), .wrBusy(wrBusy), .codecResetN(codecResetN),
    .codecCsN(codecCsN), .wrStart(wrStart), .wrAddr(wrAddr), .wrData(wrData),
    .initDone(initDone)
  );

  function automatic logic [15:0] expWrite(input int n);
    logic [6:0] a;
    logic [8:0] d;
    if (n >= 6 && n < 14)       begin a = 7'(n - 6);  d = 9'h000; end
    else if (n >= 15 && n < 23) begin a = 7'(n - 6);  d = 9'h0FF; end
    else if (n == 14)           begin a = 7'h08;      d = 9'h100; end
    else if (n == 23)           begin a = 7'h11;      d = 9'h1FF; end
    else if (n < 3)             begin a = 7'(7'h1B + n); d = (n == 0) ? 9'h044 : (n == 1) ? 9'h00B : 9'h009; end
    else if (n == 3)            begin a = 7'h18;      d = 9'h000; end
    else if (n == 4)            begin a = 7'h16;      d = 9'h122; end
    else if (n == 5)            begin a = 7'h17;      d = 9'h022; end
    else if (n >= 24 && n < 28) begin a = 7'(7'h12 + (n - 24)); d = (n == 25) ? 9'h090 : 9'h000; end
    else                        begin a = 7'(7'h19 + (n - 28)); d = 9'h000; end
    return {a, d};
  endfunction

  function automatic string reqOf(input int n);
    if (n < 4) return "R3";
    if (n < 6) return "R4";
    if (n < 15) return "R5";
    if (n < 24) return "R6";
    return "R7";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Writer model: raises busy in the request cycle, holds it a random time.
  initial begin
    int hold;
    hold = 0;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        wrBusy = 1'b0;
        hold = 0;
      end else begin
        if (wrStart) begin
          check(!wrBusy, "R8", "start while busy", 1, 0);
          if (writeCnt < NWR)
            check({wrAddr, wrData} == expWrite(writeCnt), reqOf(writeCnt),
                  $sformatf("write %0d", writeCnt), {wrAddr, wrData}, expWrite(writeCnt));
          else
            check(1'b0, "R7", "write past end", writeCnt, NWR - 1);
          writeCnt++;
          wrBusy = 1'b1;
          hold = (latMax == 0) ? 0 : int'($urandom % (latMax + 1));
        end else if (wrBusy) begin
          if (hold == 0) wrBusy = 1'b0;
          else hold--;
        end
      end
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    writeCnt = 0;
    repeat (3) @(negedge clk);
    check(codecResetN == 1'b1, "R1", "resetN in reset", codecResetN, 1);
    check(codecCsN == 1'b0, "R1", "csN in reset", codecCsN, 0);
    check(wrStart == 1'b0, "R1", "start in reset", wrStart, 0);
    check(initDone == 1'b0, "R1", "done in reset", initDone, 0);
    rstN = 1'b1;
  endtask

  task automatic checkPins();
    int n;
    @(negedge clk);
    n = 0;
    while (codecResetN == 1'b0 && codecCsN == 1'b0 && n < 1000) begin n++; @(negedge clk); end
    check(n == STEP, "R2", "reset-low phase cycles", n, STEP);
    n = 0;
    while (codecResetN == 1'b0 && codecCsN == 1'b1 && n < 1000) begin n++; @(negedge clk); end
    check(n == STEP, "R2", "cs-high phase cycles", n, STEP);
    check(codecResetN && codecCsN, "R2", "pins after release", {codecResetN, codecCsN}, 3);
    n = 0;
    while (!wrStart && n < 1000) begin
      if (!(codecResetN && codecCsN)) begin check(1'b0, "R2", "pins dropped", 0, 3); break; end
      n++; @(negedge clk);
    end
    check(n >= STEP, "R2", "wait before first write", n, STEP);
  endtask

  task automatic fullRun();
    int n;
    doReset();
    checkPins();
    n = 0;
    while (!initDone && n < 5000) begin n++; @(negedge clk); end
    check(initDone, "R7", "done raised", initDone, 1);
    check(writeCnt == NWR, "R7", "write count", writeCnt, NWR);
    repeat (40) begin
      @(negedge clk);
      check(initDone, "R9", "done held", initDone, 1);
    end
    check(writeCnt == NWR, "R7", "no writes after done", writeCnt, NWR);
  endtask

  initial begin
    int stopAt;
    void'($urandom(32'd1234));
    latMax = 0;  fullRun();
    latMax = 6;  fullRun();
    // Reset partway through the table, then a full restart.
    latMax = 3;
    doReset();
    stopAt = 8 + int'($urandom % 10);
    while (writeCnt < stopAt) @(negedge clk);
    check(!initDone, "R9", "not done midway", initDone, 0);
    fullRun();
    latMax = 1;  fullRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule